// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block moves two-channel PCM samples between a chip's core and an external converter or processor over a three-wire serial link: a bit clock, a word-sync clock and one data line in each direction. The bit clock and word-sync come from outside. They are brought into the core clock domain, and the port then works as a receiver and a transmitter at the same time, using a single frame format for both.

A 2-bit format select picks one of four frame layouts. Three layouts use 48 bit clocks per frame and place a 16-, 18- or 20-bit word at the tail of each half. The fourth layout uses 64 bit clocks per frame and starts a 16-bit word one bit clock after the word-sync edge. Received words are sign-extended to 20 bits. A source select decides whether the parallel sample outputs carry the deserialized serial words or words taken from a parallel sample port. The transmitter takes one left/right pair per frame and sends it out in the active format.

Top module: `pcm_frame_port`

## Requirements
- R1: While rst_n is low, smp_left, smp_right, smp_valid and sdout are all zero.
- R2: fmt_sel encodes the frame layout. 00 is 24 bit clocks per half with a 16-bit word. 01 is 24 per half with an 18-bit word. 10 is 24 per half with a 20-bit word. In these three, the word fills the last N bit clocks of the half, MSB first. 11 is 32 bit clocks per half with a 16-bit word whose MSB is at the second bit clock of the half. Receive ignores data outside the word.
- R3: Word-sync high marks the left half and word-sync low marks the right half. The first bit clock after a word-sync change is position 0 of the half.
- R4: Received N-bit words appear on smp_left and smp_right sign-extended to 20 bits.
- R5: smp_valid is a single-cycle pulse, raised once per frame after the right word has been received. The sample outputs hold their values between pulses.
- R6: sdout carries the transmit words in the active layout, MSB first. It is low outside the word positions and changes only after a falling bit-clock edge. Incoming data is sampled on rising edges.
- R7: The transmitted word is the low N bits of the transmit sample. The 2 lowest bits are forced to 0 in the 18-bit layout, and the 4 lowest bits in the 20-bit layout.
- R8: tx_left and tx_right are captured at the start of each left half. Changes made later in the frame appear only in the next frame.
- R9: A change of fmt_sel takes effect only at the next left-half start. A frame in progress completes in its old layout on both directions.
- R10: src_par=0 sends the serial words to the sample outputs. src_par=1 makes the valid pulse present par_left and par_right, as present in the cycle before the pulse, instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| wsync | input | 1 | External word-sync clock, high for left |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out |
| fmt_sel | input | 2 | Frame layout select |
| src_par | input | 1 | Sample source: 0 serial, 1 parallel port |
| par_left | input | 20 | Parallel-port left sample |
| par_right | input | 20 | Parallel-port right sample |
| tx_left | input | 20 | Left sample to transmit |
| tx_right | input | 20 | Right sample to transmit |
| smp_left | output | 20 | Left sample out |
| smp_right | output | 20 | Right sample out |
| smp_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The hardest situation to reach is a layout or transmit-word change that lands in the middle of a frame. The old layout must finish cleanly while the new one waits for the next left-half edge. The bench drives the link bit by bit and changes fmt_sel, tx_left and tx_right exactly at the first bit clock of the right half. It then decodes both that frame and the next with the layout each one should have. All four layouts are swept with extreme and mixed words, with ones driven on every ignored bit position, so that misplaced sampling windows or missing padding show up in the decoded values.

// File: rtl/spa_pkg.sv
package spa_pkg;
  localparam int SMP_W     = 20;
  localparam int POS_W     = 6;
  localparam int HALF_STD  = 24;
  localparam int HALF_WIDE = 32;

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [1:0] {
    FMT_TAIL16 = 2'b00,
    FMT_TAIL18 = 2'b01,
    FMT_TAIL20 = 2'b10,
    FMT_HEAD16 = 2'b11
  } fmt_t;

  function automatic pos_t half_len(fmt_t f);
    return (f == FMT_HEAD16) ? pos_t'(HALF_WIDE) : pos_t'(HALF_STD);
  endfunction

  function automatic pos_t word_len(fmt_t f);
    case (f)
      FMT_TAIL18: return pos_t'(18);
      FMT_TAIL20: return pos_t'(20);
      default:    return pos_t'(16);
    endcase
  endfunction

  function automatic pos_t win_first(fmt_t f);
    return (f == FMT_HEAD16) ? pos_t'(1) : pos_t'(half_len(f) - word_len(f));
  endfunction

  function automatic pos_t win_last(fmt_t f);
    return pos_t'(win_first(f) + word_len(f) - 1);
  endfunction

  function automatic pos_t pad_cnt(fmt_t f);
    case (f)
      FMT_TAIL18: return pos_t'(2);
      FMT_TAIL20: return pos_t'(4);
      default:    return pos_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/spa_edge_sync.sv
module spa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic ws_s,
  output logic sd_s
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            bclk_d_q;

  assign raw = {bclk_i, ws_i, sd_i};

  // equal depth on all three lines keeps data aligned with its clock edge
  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d_q <= 1'b0;
    else        bclk_d_q <= synced[2];
  end

  assign bclk_rise = synced[2] & ~bclk_d_q;
  assign bclk_fall = ~synced[2] & bclk_d_q;
  assign ws_s      = synced[1];
  assign sd_s      = synced[0];
endmodule

// File: rtl/spa_rx.sv
module spa_rx
  import spa_pkg::*;
#(
  parameter int SW = SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_rise,
  input  logic          ws_s,
  input  logic          sd_s,
  input  fmt_t          fmt,
  output logic [SW-1:0] word_q,
  output logic          done_q,
  output logic          left_q
);
  localparam int IW = $clog2(SW);

  pos_t          pos_q, pos_nxt;
  logic          ws_prev_q, ws_prev_nxt;
  logic [SW-1:0] sh_q, sh_nxt;
  logic [SW-1:0] word_nxt;
  logic          done_nxt, left_nxt;
  pos_t          first, last;
  logic [IW-1:0] msb_idx;

  always_comb begin
    first       = win_first(fmt);
    last        = win_last(fmt);
    msb_idx     = IW'(word_len(fmt) - 1'b1);
    pos_nxt     = pos_q;
    ws_prev_nxt = ws_prev_q;
    sh_nxt      = sh_q;
    word_nxt    = word_q;
    done_nxt    = 1'b0;
    left_nxt    = left_q;
    if (bit_rise) begin
      ws_prev_nxt = ws_s;
      if (ws_s != ws_prev_q)  pos_nxt = '0;
      else if (pos_q != '1)   pos_nxt = pos_q + 1'b1;
      if (pos_nxt >= first && pos_nxt <= last)
        sh_nxt = {sh_q[SW-2:0], sd_s};
      if (pos_nxt == last) begin
        done_nxt = 1'b1;
        left_nxt = ws_s;
        for (int i = 0; i < SW; i++)
          word_nxt[i] = (IW'(i) <= msb_idx) ? sh_nxt[i] : sh_nxt[msb_idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      ws_prev_q <= 1'b0;
      sh_q      <= '0;
      word_q    <= '0;
      done_q    <= 1'b0;
      left_q    <= 1'b0;
    end else begin
      pos_q     <= pos_nxt;
      ws_prev_q <= ws_prev_nxt;
      sh_q      <= sh_nxt;
      word_q    <= word_nxt;
      done_q    <= done_nxt;
      left_q    <= left_nxt;
    end
  end
endmodule

// File: rtl/spa_tx.sv
module spa_tx
  import spa_pkg::*;
#(
  parameter int SW = SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_fall,
  input  logic          ws_s,
  input  fmt_t          fmt_req,
  input  logic [SW-1:0] in_l,
  input  logic [SW-1:0] in_r,
  output logic          sd_q,
  output fmt_t          fmt_q,
  output logic          frame_start
);
  localparam int IW = $clog2(SW);

  pos_t          pos_q, pos_nxt;
  logic          ws_prev_q, ws_prev_nxt;
  logic [SW-1:0] lat_l_q, lat_l_nxt, lat_r_q, lat_r_nxt;
  fmt_t          fmt_nxt, fmt_use;
  logic          sd_nxt, bit_val;
  logic [SW-1:0] word_sel, word_pad;
  pos_t          first, last, offs;
  logic [IW-1:0] bit_idx;

  assign frame_start = bit_fall & ws_s & ~ws_prev_q;

  always_comb begin
    fmt_use     = frame_start ? fmt_req : fmt_q;
    first       = win_first(fmt_use);
    last        = win_last(fmt_use);
    pos_nxt     = pos_q;
    ws_prev_nxt = ws_prev_q;
    lat_l_nxt   = lat_l_q;
    lat_r_nxt   = lat_r_q;
    fmt_nxt     = fmt_q;
    sd_nxt      = sd_q;
    if (bit_fall) begin
      ws_prev_nxt = ws_s;
      if (ws_s != ws_prev_q) pos_nxt = '0;
      else if (pos_q != '1)  pos_nxt = pos_q + 1'b1;
    end
    word_sel = ws_s ? (frame_start ? in_l : lat_l_q) : lat_r_q;
    for (int i = 0; i < SW; i++)
      word_pad[i] = (pos_t'(i) < pad_cnt(fmt_use)) ? 1'b0 : word_sel[i];
    offs    = pos_nxt - first;
    bit_idx = IW'(word_len(fmt_use) - 1'b1 - offs);
    bit_val = (pos_nxt >= first && pos_nxt <= last) ? word_pad[bit_idx] : 1'b0;
    if (bit_fall) sd_nxt = bit_val;
    if (frame_start) begin
      fmt_nxt   = fmt_req;
      lat_l_nxt = in_l;
      lat_r_nxt = in_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      ws_prev_q <= 1'b0;
      lat_l_q   <= '0;
      lat_r_q   <= '0;
      fmt_q     <= FMT_TAIL16;
      sd_q      <= 1'b0;
    end else begin
      pos_q     <= pos_nxt;
      ws_prev_q <= ws_prev_nxt;
      lat_l_q   <= lat_l_nxt;
      lat_r_q   <= lat_r_nxt;
      fmt_q     <= fmt_nxt;
      sd_q      <= sd_nxt;
    end
  end
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import spa_pkg::*;
#(
  parameter int SW          = SMP_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          wsync,
  input  logic          sdin,
  output logic          sdout,
  input  logic [1:0]    fmt_sel,
  input  logic          src_par,
  input  logic [SW-1:0] par_left,
  input  logic [SW-1:0] par_right,
  input  logic [SW-1:0] tx_left,
  input  logic [SW-1:0] tx_right,
  output logic [SW-1:0] smp_left,
  output logic [SW-1:0] smp_right,
  output logic          smp_valid
);
  logic          bclk_rise, bclk_fall, ws_s, sd_s;
  logic [SW-1:0] rx_word;
  logic          rx_done, rx_left;
  fmt_t          fmt_act;
  logic          frame_start;
  logic [SW-1:0] hold_l_q, hold_l_nxt, smp_l_nxt, smp_r_nxt;
  logic          valid_nxt;

  spa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .ws_i(wsync), .sd_i(sdin),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .ws_s(ws_s), .sd_s(sd_s)
  );

  // format register lives in the transmitter; it updates on the falling
  // edge that opens a left half, ahead of any receive bit of that frame
  spa_tx #(.SW(SW)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_fall(bclk_fall), .ws_s(ws_s),
    .fmt_req(fmt_t'(fmt_sel)), .in_l(tx_left), .in_r(tx_right),
    .sd_q(sdout), .fmt_q(fmt_act), .frame_start(frame_start)
  );

  spa_rx #(.SW(SW)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bclk_rise), .ws_s(ws_s), .sd_s(sd_s),
    .fmt(fmt_act), .word_q(rx_word), .done_q(rx_done), .left_q(rx_left)
  );

  always_comb begin
    hold_l_nxt = hold_l_q;
    smp_l_nxt  = smp_left;
    smp_r_nxt  = smp_right;
    valid_nxt  = 1'b0;
    if (rx_done) begin
      if (rx_left) begin
        hold_l_nxt = rx_word;
      end else begin
        valid_nxt = 1'b1;
        smp_l_nxt = src_par ? par_left  : hold_l_q;
        smp_r_nxt = src_par ? par_right : rx_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q  <= '0;
      smp_left  <= '0;
      smp_right <= '0;
      smp_valid <= 1'b0;
    end else begin
      hold_l_q  <= hold_l_nxt;
      smp_left  <= smp_l_nxt;
      smp_right <= smp_r_nxt;
      smp_valid <= valid_nxt;
    end
  end
endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk #(
  parameter int SW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdout,
  input logic          bclk_fall,
  input logic          frame_start,
  input logic [1:0]    fmt_act,
  input logic          src_par,
  input logic [SW-1:0] par_left,
  input logic [SW-1:0] par_right,
  input logic [SW-1:0] smp_left,
  input logic [SW-1:0] smp_right,
  input logic          smp_valid
);
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ($stable(smp_left) && $stable(smp_right)));

  p_tx_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(bclk_fall));

  p_fmt_at_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_act) |-> $past(frame_start));

  p_par_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(src_par)) |->
      (smp_left == $past(par_left) && smp_right == $past(par_right)));
endmodule

bind pcm_frame_port pcm_frame_port_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdout(sdout), .bclk_fall(bclk_fall),
  .frame_start(frame_start), .fmt_act(fmt_act), .src_par(src_par),
  .par_left(par_left), .par_right(par_right), .smp_left(smp_left),
  .smp_right(smp_right), .smp_valid(smp_valid)
);

// File: tb/tb_pcm_frame_port.sv
module tb_pcm_frame_port;
  logic        clk = 1'b0;
  logic        rst_n, bclk, wsync, sdin, sdout, src_par, smp_valid;
  logic [1:0]  fmt_sel;
  logic [19:0] par_left, par_right, tx_left, tx_right, smp_left, smp_right;
  int          total = 0, bad = 0, vcount = 0;
  logic [19:0] cap_l, cap_r;
  bit          finished = 0;

  always #5 clk = ~clk;

  pcm_frame_port dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wsync(wsync), .sdin(sdin),
    .sdout(sdout), .fmt_sel(fmt_sel), .src_par(src_par),
    .par_left(par_left), .par_right(par_right), .tx_left(tx_left),
    .tx_right(tx_right), .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid)
  );

  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      vcount++;
      cap_l = smp_left;
      cap_r = smp_right;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int hl(input int f); return (f == 3) ? 32 : 24; endfunction
  function automatic int wn(input int f); return (f == 1) ? 18 : (f == 2) ? 20 : 16; endfunction
  function automatic int st(input int f); return (f == 3) ? 1 : hl(f) - wn(f); endfunction
  function automatic int pd(input int f); return (f == 1) ? 2 : (f == 2) ? 4 : 0; endfunction

  function automatic logic [19:0] sext(input logic [19:0] v, input int n);
    logic [19:0] r;
    for (int i = 0; i < 20; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  function automatic logic [19:0] txexp(input logic [19:0] v, input int f);
    logic [19:0] r;
    for (int i = 0; i < 20; i++) r[i] = (i < wn(f) && i >= pd(f)) ? v[i] : 1'b0;
    return r;
  endfunction

  function automatic logic [19:0] pat(input int k, input int salt, input int n);
    logic [19:0] one = 20'd1;
    case ((k + salt) % 6)
      0: return 20'h00000;
      1: return 20'hFFFFF;
      2: return one << (n - 1);
      3: return (one << (n - 1)) - 20'd1;
      4: return 20'h5A5A5 ^ 20'(salt * 20'h3C3C3);
      default: return 20'((32'h9E3779B1 * (k + 7 + salt * 13)) >> 9);
    endcase
  endfunction

  // drive one frame in layout f; at right-half start apply mid-frame values
  task automatic frame(input int f, input logic [19:0] l, input logic [19:0] r,
                       input logic [1:0] mfmt, input logic [19:0] mtl,
                       input logic [19:0] mtr, output logic [19:0] gl,
                       output logic [19:0] gr, output int stray);
    int h_len = hl(f), n = wn(f), s = st(f);
    gl = '0; gr = '0; stray = 0;
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < h_len; p++) begin
        logic [19:0] w = (h == 0) ? l : r;
        bit inwin = (p >= s) && (p < s + n);
        @(negedge clk);
        bclk  = 1'b0;
        wsync = (h == 0);
        sdin  = inwin ? w[n-1-(p-s)] : 1'b1;
        if (h == 1 && p == 0) begin
          fmt_sel = mfmt; tx_left = mtl; tx_right = mtr;
        end
        repeat (3) @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        if (inwin) begin
          if (h == 0) gl[n-1-(p-s)] = sdout; else gr[n-1-(p-s)] = sdout;
        end else begin
          stray += int'(sdout);
        end
        repeat (3) @(negedge clk);
      end
    end
    repeat (16) @(negedge clk);
  endtask

  task automatic run(input int f, input logic [19:0] l, input logic [19:0] r,
                     input logic [19:0] tl, input logic [19:0] tr);
    logic [19:0] gl, gr;
    int stray, v0;
    fmt_sel = 2'(f); tx_left = tl; tx_right = tr;
    v0 = vcount;
    frame(f, l, r, 2'(f), tl, tr, gl, gr, stray);
    chk("R5 one valid per frame", 32'(vcount), 32'(v0 + 1));
    chk("R2/R4 left rx", 32'(cap_l), 32'(sext(l, wn(f))));
    chk("R3/R4 right rx", 32'(cap_r), 32'(sext(r, wn(f))));
    chk("R6/R7 left tx", 32'(gl), 32'(txexp(tl, f)));
    chk("R6/R7 right tx", 32'(gr), 32'(txexp(tr, f)));
    chk("R6 low outside word", 32'(stray), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] gl, gr;
    int stray, v0;
    rst_n = 1'b0; bclk = 1'b1; wsync = 1'b0; sdin = 1'b0; fmt_sel = 2'b00;
    src_par = 1'b0; par_left = '0; par_right = '0; tx_left = '0; tx_right = '0;
    repeat (5) @(negedge clk);
    chk("R1 smp_left", 32'(smp_left), 32'd0);
    chk("R1 smp_right", 32'(smp_right), 32'd0);
    chk("R1 smp_valid", 32'(smp_valid), 32'd0);
    chk("R1 sdout", 32'(sdout), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R4 R5 R6 R7: every layout with extreme and mixed words
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 6; k++)
        run(f, pat(k, 0, wn(f)), pat(k, 1, wn(f)), pat(k, 2, wn(f)), pat(k, 3, wn(f)));

    // R9: layout request changes mid-frame, applies only to the next frame
    fmt_sel = 2'b00; tx_left = 20'h0ABCD; tx_right = 20'h01234;
    v0 = vcount;
    frame(0, 20'h0F00F, 20'h08001, 2'b11, 20'h0ABCD, 20'h01234, gl, gr, stray);
    chk("R9 old layout rx left", 32'(cap_l), 32'(sext(20'h0F00F, 16)));
    chk("R9 old layout rx right", 32'(cap_r), 32'(sext(20'h08001, 16)));
    chk("R9 old layout tx left", 32'(gl), 32'(txexp(20'h0ABCD, 0)));
    chk("R9 old layout stray", 32'(stray), 32'd0);
    frame(3, 20'h07FFE, 20'h0C003, 2'b11, 20'h0ABCD, 20'h01234, gl, gr, stray);
    chk("R9 new layout rx left", 32'(cap_l), 32'(sext(20'h07FFE, 16)));
    chk("R9 new layout rx right", 32'(cap_r), 32'(sext(20'h0C003, 16)));
    chk("R9 new layout tx right", 32'(gr), 32'(txexp(20'h01234, 3)));
    chk("R9 valid count", 32'(vcount), 32'(v0 + 2));

    // R8: transmit inputs change mid-frame, sent one frame later
    fmt_sel = 2'b10; tx_left = 20'hA5A5F; tx_right = 20'h3C3C7;
    frame(2, 20'h12345, 20'hFEDCB, 2'b10, 20'h6789B, 20'h9ABCF, gl, gr, stray);
    chk("R8 left held", 32'(gl), 32'(txexp(20'hA5A5F, 2)));
    chk("R8 right held", 32'(gr), 32'(txexp(20'h3C3C7, 2)));
    frame(2, 20'h12345, 20'hFEDCB, 2'b10, 20'h6789B, 20'h9ABCF, gl, gr, stray);
    chk("R8 left next frame", 32'(gl), 32'(txexp(20'h6789B, 2)));
    chk("R8 right next frame", 32'(gr), 32'(txexp(20'h9ABCF, 2)));

    // R10: parallel port as sample source, then back to serial
    src_par = 1'b1; par_left = 20'h13579; par_right = 20'hEDCBA; fmt_sel = 2'b01;
    v0 = vcount;
    frame(1, 20'h2AAAA, 20'h15555, 2'b01, tx_left, tx_right, gl, gr, stray);
    chk("R10 parallel left", 32'(cap_l), 32'h13579);
    chk("R10 parallel right", 32'(cap_r), 32'hEDCBA);
    chk("R10 valid count", 32'(vcount), 32'(v0 + 1));
    src_par = 1'b0;
    frame(1, 20'h2AAAA, 20'h15555, 2'b01, tx_left, tx_right, gl, gr, stray);
    chk("R10 serial left", 32'(cap_l), 32'(sext(20'h2AAAA, 18)));
    chk("R10 serial right", 32'(cap_r), 32'(sext(20'h15555, 18)));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule